// File: doc/BRIEF.md
# Legacy I/O chip-select decoder

This block turns ISA I/O cycles into active-low chip selects for the fixed-address peripherals of a PC-style motherboard. Those peripherals are a keyboard controller, an embedded microcontroller and the data port of a real-time clock. It also produces a short index-latch strobe for the clock's address register. Two further selects cover software-defined I/O windows. These fire only for cycles issued by a PCI master, and they also enable the external byte-wide peripheral buffer and set its direction.

The fixed selects are combinational functions of the address lines and the I/O command strobes. The index strobe is timed on the system clock: it starts when the write command is seen falling and lasts a fixed number of clocks. The keyboard select, the clock data select and the index strobe can each be handed over to a configuration bit, so that the pin serves as a general-purpose output.

Top module: `legacy_io_decode`

## Requirements
- R1: `kbd_cs_no` is low while `ior_ni` or `iow_ni` is low and `sa_i[15:0]` is 16'h0060 or 16'h0064. Otherwise it is high.
- R2: `mcu_cs_no` is low while `ior_ni` or `iow_ni` is low and `sa_i[15:0]` is 16'h0062 or 16'h0066. Otherwise it is high.
- R3: `rtc_data_cs_no` is low while `ior_ni` or `iow_ni` is low and `sa_i[15:0]` is 16'h0071. Otherwise it is high.
- R4: When a rising `clk_i` edge finds `iow_ni` low, the previous edge found it high, and `sa_i[15:0]` is 16'h0070, then `idx_stb_o` goes high after that edge and stays high for exactly 2 clock periods (ALE_CYCLES). Reads and other addresses never start it.
- R5: The fixed selects, the index strobe and the window selects only respond when `sa_i[19:16]` and `la_i` (address bits 23:17) are all zero. With both command strobes high, no select is driven low.
- R6: Bit i of `win_cs_no` is low when all of the following hold: `pci_cycle_i` is high, a command strobe is low, the high address bits are zero, and `sa_i[15:0]` equals `win_base_i[i]` in every bit position where `win_mask_i[i]` is 0. A mask bit of 1 makes that bit don't-care.
- R7: `xbuf_en_no` is low while any bit of `win_cs_no` is low. `xbuf_rd_no` is low while any bit of `win_cs_no` is low and `ior_ni` is low. Otherwise both are high.
- R8: While `rst_ni` is low, all selects and both buffer controls are high and `idx_stb_o` is low. This holds regardless of the address, command and general-purpose settings. The strobe timer is cleared.
- R9: When `kbd_gpo_en_i`, `rtc_gpo_en_i` or `idx_gpo_en_i` is high, the matching output follows its `_gpo_val_i` bit, and address decoding has no effect on that output.
- R10: A qualifying write fall that occurs while `idx_stb_o` is already high restarts the 2-cycle count from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock for the strobe timer |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sa_i | input | 20 | Latched system address |
| la_i | input | 7 | Unlatched address bits 23:17 |
| ior_ni | input | 1 | I/O read command, active low |
| iow_ni | input | 1 | I/O write command, active low |
| pci_cycle_i | input | 1 | Current cycle was issued by a PCI master |
| win_base_i | input | NUM_RANGES x 16 | Base address of each I/O window |
| win_mask_i | input | NUM_RANGES x 16 | Don't-care bits of each window |
| kbd_gpo_en_i | input | 1 | Keyboard select used as general-purpose output |
| kbd_gpo_val_i | input | 1 | Level driven in that mode |
| rtc_gpo_en_i | input | 1 | Clock data select used as general-purpose output |
| rtc_gpo_val_i | input | 1 | Level driven in that mode |
| idx_gpo_en_i | input | 1 | Index strobe used as general-purpose output |
| idx_gpo_val_i | input | 1 | Level driven in that mode |
| kbd_cs_no | output | 1 | Keyboard controller select |
| mcu_cs_no | output | 1 | Microcontroller select |
| rtc_data_cs_no | output | 1 | Real-time clock data select |
| win_cs_no | output | NUM_RANGES | Window selects |
| idx_stb_o | output | 1 | Clock index latch strobe |
| xbuf_en_no | output | 1 | Peripheral buffer enable |
| xbuf_rd_no | output | 1 | Peripheral buffer direction, low toward the host |

## Verification
Two functions can act on the same write cycle. The timed index strobe and a window select meet when a window is configured over port 70h and a PCI-master write falls on that address. In that cycle both the window select and the buffer enable must be active while the strobe starts its count. A read of 71h inside the same window makes the clock data select and the window select active together, with the buffer direction turned toward the host. A behavioural per-cycle model predicts all outputs independently, and every output is compared with it on each falling clock edge.

// File: rtl/legacy_io_pkg.sv
package legacy_io_pkg;
  localparam int unsigned IO_AW = 16;
  localparam int unsigned SA_W  = 20;
  localparam int unsigned LA_W  = 7;

  localparam logic [IO_AW-1:0] KBD_DATA_PORT = 16'h0060;
  localparam logic [IO_AW-1:0] KBD_CMD_PORT  = 16'h0064;
  localparam logic [IO_AW-1:0] MCU_DATA_PORT = 16'h0062;
  localparam logic [IO_AW-1:0] MCU_CMD_PORT  = 16'h0066;
  localparam logic [IO_AW-1:0] RTC_IDX_PORT  = 16'h0070;
  localparam logic [IO_AW-1:0] RTC_DATA_PORT = 16'h0071;

  typedef struct packed {
    logic kbd;
    logic mcu;
    logic rtc;
    logic idx;
  } fixed_hit_t;
endpackage

// File: rtl/legacy_io_port_match.sv
module legacy_io_port_match #(
  parameter int unsigned     AW     = 16,
  parameter logic [AW-1:0]   PORT_A = '0,
  parameter logic [AW-1:0]   PORT_B = '0
) (
  input  logic [AW-1:0] addr_i,
  input  logic          qual_i,
  output logic          hit_o
);
  logic eq_a, eq_b;

  assign eq_a  = (addr_i == PORT_A);
  assign eq_b  = (addr_i == PORT_B);
  assign hit_o = qual_i & (eq_a | eq_b);
endmodule

// File: rtl/legacy_io_range_match.sv
module legacy_io_range_match #(
  parameter int unsigned NUM_RANGES = 2,
  parameter int unsigned AW         = 16
) (
  input  logic [AW-1:0]                 addr_i,
  input  logic [NUM_RANGES-1:0][AW-1:0] base_i,
  input  logic [NUM_RANGES-1:0][AW-1:0] mask_i,
  input  logic                          qual_i,
  output logic [NUM_RANGES-1:0]         hit_o
);
  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
    logic [AW-1:0] diff;
    // mask bit set = don't care
    assign diff     = (addr_i ^ base_i[g]) & ~mask_i[g];
    assign hit_o[g] = qual_i & (diff == '0);
  end
endmodule

// File: rtl/legacy_io_idx_timer.sv
module legacy_io_idx_timer #(
  parameter int unsigned CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic iow_ni,
  input  logic idx_hit_i,
  output logic stb_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic          iow_q;
  logic          wr_fall;
  logic [CW-1:0] cnt_q;

  assign wr_fall = iow_q & ~iow_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iow_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      iow_q <= iow_ni;
      if (wr_fall && idx_hit_i) begin
        cnt_q <= CW'(CYCLES);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign stb_o = (cnt_q != '0);
endmodule

// File: rtl/legacy_io_decode.sv
module legacy_io_decode
  import legacy_io_pkg::*;
#(
  parameter int unsigned NUM_RANGES = 2,
  parameter int unsigned ALE_CYCLES = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [SA_W-1:0]                  sa_i,
  input  logic [LA_W-1:0]                  la_i,
  input  logic                             ior_ni,
  input  logic                             iow_ni,
  input  logic                             pci_cycle_i,
  input  logic [NUM_RANGES-1:0][IO_AW-1:0] win_base_i,
  input  logic [NUM_RANGES-1:0][IO_AW-1:0] win_mask_i,
  input  logic                             kbd_gpo_en_i,
  input  logic                             kbd_gpo_val_i,
  input  logic                             rtc_gpo_en_i,
  input  logic                             rtc_gpo_val_i,
  input  logic                             idx_gpo_en_i,
  input  logic                             idx_gpo_val_i,
  output logic                             kbd_cs_no,
  output logic                             mcu_cs_no,
  output logic                             rtc_data_cs_no,
  output logic [NUM_RANGES-1:0]            win_cs_no,
  output logic                             idx_stb_o,
  output logic                             xbuf_en_no,
  output logic                             xbuf_rd_no
);
  logic                  low_space;
  logic                  io_access;
  logic [IO_AW-1:0]      io_addr;
  logic                  fixed_qual;
  logic                  idx_qual;
  logic                  win_qual;
  fixed_hit_t            hit;
  logic [NUM_RANGES-1:0] win_hit;
  logic                  any_win;
  logic                  stb_raw;

  assign low_space  = (sa_i[SA_W-1:IO_AW] == '0) && (la_i == '0);
  assign io_access  = ~ior_ni | ~iow_ni;
  assign io_addr    = sa_i[IO_AW-1:0];
  assign fixed_qual = low_space & io_access;
  assign idx_qual   = low_space & ~iow_ni;
  assign win_qual   = fixed_qual & pci_cycle_i;

  legacy_io_port_match #(
    .AW(IO_AW), .PORT_A(KBD_DATA_PORT), .PORT_B(KBD_CMD_PORT)
  ) u_kbd (
    .addr_i(io_addr), .qual_i(fixed_qual), .hit_o(hit.kbd)
  );

  legacy_io_port_match #(
    .AW(IO_AW), .PORT_A(MCU_DATA_PORT), .PORT_B(MCU_CMD_PORT)
  ) u_mcu (
    .addr_i(io_addr), .qual_i(fixed_qual), .hit_o(hit.mcu)
  );

  legacy_io_port_match #(
    .AW(IO_AW), .PORT_A(RTC_DATA_PORT), .PORT_B(RTC_DATA_PORT)
  ) u_rtc (
    .addr_i(io_addr), .qual_i(fixed_qual), .hit_o(hit.rtc)
  );

  legacy_io_port_match #(
    .AW(IO_AW), .PORT_A(RTC_IDX_PORT), .PORT_B(RTC_IDX_PORT)
  ) u_idx (
    .addr_i(io_addr), .qual_i(idx_qual), .hit_o(hit.idx)
  );

  legacy_io_range_match #(
    .NUM_RANGES(NUM_RANGES), .AW(IO_AW)
  ) u_win (
    .addr_i(io_addr), .base_i(win_base_i), .mask_i(win_mask_i),
    .qual_i(win_qual), .hit_o(win_hit)
  );

  legacy_io_idx_timer #(
    .CYCLES(ALE_CYCLES)
  ) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .iow_ni(iow_ni),
    .idx_hit_i(hit.idx), .stb_o(stb_raw)
  );

  assign any_win = |win_hit;

  // reset overrides decode and general-purpose modes
  always_comb begin
    if (!rst_ni) begin
      kbd_cs_no      = 1'b1;
      mcu_cs_no      = 1'b1;
      rtc_data_cs_no = 1'b1;
      win_cs_no      = '1;
      idx_stb_o      = 1'b0;
      xbuf_en_no     = 1'b1;
      xbuf_rd_no     = 1'b1;
    end else begin
      kbd_cs_no      = kbd_gpo_en_i ? kbd_gpo_val_i : ~hit.kbd;
      mcu_cs_no      = ~hit.mcu;
      rtc_data_cs_no = rtc_gpo_en_i ? rtc_gpo_val_i : ~hit.rtc;
      win_cs_no      = ~win_hit;
      idx_stb_o      = idx_gpo_en_i ? idx_gpo_val_i : stb_raw;
      xbuf_en_no     = ~any_win;
      xbuf_rd_no     = ~(any_win & ~ior_ni);
    end
  end
endmodule

// File: rtl/legacy_io_decode_chk.sv
module legacy_io_decode_chk #(
  parameter int unsigned NUM_RANGES = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [19:0]           sa_i,
  input logic [6:0]            la_i,
  input logic                  ior_ni,
  input logic                  iow_ni,
  input logic                  pci_cycle_i,
  input logic                  kbd_gpo_en_i,
  input logic                  rtc_gpo_en_i,
  input logic                  idx_gpo_en_i,
  input logic                  kbd_cs_no,
  input logic                  mcu_cs_no,
  input logic                  rtc_data_cs_no,
  input logic [NUM_RANGES-1:0] win_cs_no,
  input logic                  idx_stb_o,
  input logic                  xbuf_en_no,
  input logic                  xbuf_rd_no
);
  p_reset_idle_r8: assert property (@(posedge clk_i)
    !rst_ni |-> (kbd_cs_no && mcu_cs_no && rtc_data_cs_no && (&win_cs_no)
                 && xbuf_en_no && xbuf_rd_no && !idx_stb_o));

  p_kbd_decode_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!kbd_gpo_en_i && !kbd_cs_no) |->
      ((sa_i[15:0] == 16'h0060 || sa_i[15:0] == 16'h0064) && (!ior_ni || !iow_ni)));

  p_mcu_decode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mcu_cs_no |-> ((sa_i[15:0] == 16'h0062 || sa_i[15:0] == 16'h0066)
                    && (!ior_ni || !iow_ni)));

  p_rtc_decode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rtc_gpo_en_i && !rtc_data_cs_no) |->
      (sa_i[15:0] == 16'h0071 && (!ior_ni || !iow_ni)));

  p_idx_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(idx_stb_o) && !idx_gpo_en_i && $past(!idx_gpo_en_i)) |->
      $past(!iow_ni && sa_i[15:0] == 16'h0070));

  p_idx_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(idx_stb_o) && !idx_gpo_en_i && $past(!idx_gpo_en_i)) |=>
      (idx_stb_o || idx_gpo_en_i));

  p_low_space_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mcu_cs_no || !(&win_cs_no)) |-> (sa_i[19:16] == 4'h0 && la_i == 7'h00));

  p_win_pci_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&win_cs_no) |-> (pci_cycle_i && (!ior_ni || !iow_ni)));

  p_buf_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&win_cs_no) |-> !xbuf_en_no);

  p_buf_rd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xbuf_rd_no |-> (!xbuf_en_no && !ior_ni));
endmodule

bind legacy_io_decode legacy_io_decode_chk #(.NUM_RANGES(NUM_RANGES)) u_chk (.*);

// File: tb/legacy_io_decode_test.sv
module legacy_io_decode_test;
  localparam int NR = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [19:0]       sa;
  logic [6:0]        la;
  logic              ior_n, iow_n, pci;
  logic [NR-1:0][15:0] base, mask;
  logic              kgo_en, kgo_v, rgo_en, rgo_v, igo_en, igo_v;
  logic              kbd_cs_n, mcu_cs_n, rtc_cs_n, stb, buf_en_n, buf_rd_n;
  logic [NR-1:0]     win_cs_n;

  int    checks = 0;
  int    errors = 0;
  string phase  = "R8";
  bit    done   = 0;

  always #2.5 clk = ~clk;

  legacy_io_decode #(.NUM_RANGES(NR), .ALE_CYCLES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sa_i(sa), .la_i(la),
    .ior_ni(ior_n), .iow_ni(iow_n), .pci_cycle_i(pci),
    .win_base_i(base), .win_mask_i(mask),
    .kbd_gpo_en_i(kgo_en), .kbd_gpo_val_i(kgo_v),
    .rtc_gpo_en_i(rgo_en), .rtc_gpo_val_i(rgo_v),
    .idx_gpo_en_i(igo_en), .idx_gpo_val_i(igo_v),
    .kbd_cs_no(kbd_cs_n), .mcu_cs_no(mcu_cs_n), .rtc_data_cs_no(rtc_cs_n),
    .win_cs_no(win_cs_n), .idx_stb_o(stb),
    .xbuf_en_no(buf_en_n), .xbuf_rd_no(buf_rd_n)
  );

  // reference strobe model
  int m_cnt;
  bit m_prev_w;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt    <= 0;
      m_prev_w <= 1;
    end else begin
      m_prev_w <= iow_n;
      if (m_prev_w && !iow_n && sa[15:0] == 16'h0070 && sa[19:16] == 0 && la == 0)
        m_cnt <= 2;
      else if (m_cnt > 0)
        m_cnt <= m_cnt - 1;
    end
  end

  task automatic cmp(input string tag, input string nm, input logic [3:0] act,
                     input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (phase %s) %s act=%b exp=%b t=%0t", tag, phase, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit          low, acc, any;
    logic [15:0] a;
    logic        e_kbd, e_mcu, e_rtc, e_stb, e_en, e_rd;
    logic [NR-1:0] e_win;
    a   = sa[15:0];
    low = (sa[19:16] == 0) && (la == 0);
    acc = (ior_n == 0) || (iow_n == 0);
    e_kbd = 1; e_mcu = 1; e_rtc = 1;
    if (low && acc) begin
      case (a)
        16'h0060, 16'h0064: e_kbd = 0;
        16'h0062, 16'h0066: e_mcu = 0;
        16'h0071:           e_rtc = 0;
        default: ;
      endcase
    end
    any = 0;
    for (int i = 0; i < NR; i++) begin
      e_win[i] = !(pci && low && acc && ((a & ~mask[i]) == (base[i] & ~mask[i])));
      if (!e_win[i]) any = 1;
    end
    if (kgo_en) e_kbd = kgo_v;
    if (rgo_en) e_rtc = rgo_v;
    e_stb = igo_en ? igo_v : (m_cnt > 0);
    e_en  = !any;
    e_rd  = !(any && !ior_n);
    if (!rst_n) begin
      e_kbd = 1; e_mcu = 1; e_rtc = 1; e_win = '1; e_stb = 0; e_en = 1; e_rd = 1;
    end
    cmp("R1", "kbd_cs_no", {3'b0, kbd_cs_n}, {3'b0, e_kbd});
    cmp("R2", "mcu_cs_no", {3'b0, mcu_cs_n}, {3'b0, e_mcu});
    cmp("R3", "rtc_data_cs_no", {3'b0, rtc_cs_n}, {3'b0, e_rtc});
    cmp("R4", "idx_stb_o", {3'b0, stb}, {3'b0, e_stb});
    cmp("R6", "win_cs_no", {2'b0, win_cs_n}, {2'b0, e_win});
    cmp("R7", "xbuf_en_no", {3'b0, buf_en_n}, {3'b0, e_en});
    cmp("R7", "xbuf_rd_no", {3'b0, buf_rd_n}, {3'b0, e_rd});
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic io_cyc(input logic [19:0] a, input logic [6:0] l, input bit rd,
                        input bit p, input int n);
    @(posedge clk); #1;
    sa = a; la = l; pci = p;
    if (rd) ior_n = 0; else iow_n = 0;
    repeat (n) @(posedge clk);
    #1;
    ior_n = 1; iow_n = 1;
    idle(2);
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    // R8: reset suppresses decode and general-purpose levels
    rst_n = 0; sa = 20'h00060; la = 0; ior_n = 0; iow_n = 1; pci = 1;
    base[0] = 16'h0060; mask[0] = 16'h0; base[1] = 16'h0400; mask[1] = 16'h0;
    kgo_en = 0; kgo_v = 0; rgo_en = 0; rgo_v = 0; igo_en = 1; igo_v = 1;
    idle(4);
    ior_n = 1; igo_en = 0; pci = 0; base[0] = 16'h0300; mask[0] = 16'h000F;
    idle(1);
    rst_n = 1;
    idle(2);

    phase = "R1";
    io_cyc(20'h00060, 0, 1, 0, 3);
    io_cyc(20'h00064, 0, 0, 0, 3);
    io_cyc(20'h00061, 0, 1, 0, 2);
    phase = "R2";
    io_cyc(20'h00062, 0, 0, 0, 2);
    io_cyc(20'h00066, 0, 1, 0, 2);
    phase = "R3";
    io_cyc(20'h00071, 0, 1, 0, 2);
    io_cyc(20'h00071, 0, 0, 0, 2);
    phase = "R4";
    io_cyc(20'h00070, 0, 0, 0, 5);
    io_cyc(20'h00070, 0, 1, 0, 4);
    io_cyc(20'h00072, 0, 0, 0, 4);
    phase = "R5";
    io_cyc(20'h10060, 0, 1, 0, 2);
    io_cyc(20'h00064, 7'h01, 0, 0, 2);
    io_cyc(20'h20070, 0, 0, 0, 4);
    sa = 20'h00060; idle(3);
    phase = "R6";
    io_cyc(20'h00305, 0, 1, 1, 2);
    io_cyc(20'h00305, 0, 1, 0, 2);
    io_cyc(20'h00310, 0, 1, 1, 2);
    io_cyc(20'h00400, 0, 0, 1, 2);
    io_cyc(20'h00401, 0, 1, 1, 2);
    io_cyc(20'h10400, 0, 1, 1, 2);
    phase = "R10";
    @(posedge clk); #1;
    sa = 20'h00070; iow_n = 0; idle(1);
    iow_n = 1; idle(1);
    iow_n = 0; idle(1);
    iow_n = 1; idle(4);
    phase = "R9";
    kgo_en = 1; kgo_v = 0;
    io_cyc(20'h00061, 0, 1, 0, 2);
    kgo_v = 1;
    io_cyc(20'h00060, 0, 1, 0, 2);
    kgo_en = 0; rgo_en = 1; rgo_v = 1;
    io_cyc(20'h00071, 0, 0, 0, 2);
    rgo_v = 0; idle(2);
    rgo_en = 0; igo_en = 1; igo_v = 0;
    io_cyc(20'h00070, 0, 0, 0, 3);
    igo_v = 1; idle(2);
    igo_en = 0; idle(3);
    phase = "R4+R6";
    // window over the index/data pair, overlapping strobe and selects
    base[0] = 16'h0070; mask[0] = 16'h0001;
    io_cyc(20'h00070, 0, 0, 1, 3);
    io_cyc(20'h00071, 0, 1, 1, 3);
    phase = "R8";
    @(posedge clk); #1;
    sa = 20'h00070; iow_n = 0; idle(1);
    rst_n = 0; idle(2);
    iow_n = 1; rst_n = 1; idle(4);
    done = 1;
    finish_up();
  end
endmodule